// File: doc/BRIEF.md
# Burst Address Order Sequencer

This block produces the two least significant address bits for a four-beat burst. When a new access is taken it captures the caller's starting low bits. Each later advance moves to the next beat, and the low bits follow one of two orders. A static strap picks the order. Linear order counts upward from the start value and wraps inside the same group of four. Interleaved order combines the start value with the beat number by exclusive-or. The upper address bits go around this block unchanged, and the memory array sits outside it.

All state changes happen on a rising clock edge, and only while the active-low clock enable is asserted. One control input decides between taking a new start value and stepping the burst. The block reads the order strap while reset is high and keeps that value until the next reset. A mode pin that is noisy or driven after reset therefore cannot change the order in the middle of a burst.

Top module: `burst_seq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `low_addr` = 0 and `beat_idx` = 0.
- R2: At an edge with `clk_en_n` = 0 and `adv_ld` = 0, the block captures `start_addr`. After that edge `low_addr` equals the captured value and `beat_idx` = 0.
- R3: When the latched order is linear (strap value 0), `low_addr` = (start + `beat_idx`) mod 4. For a start of 1 the beats give 1, 2, 3, 0.
- R4: When the latched order is interleaved (strap value 1), `low_addr` = start XOR `beat_idx`. For a start of 1 the beats give 1, 0, 3, 2.
- R5: At an edge with `clk_en_n` = 0 and `adv_ld` = 1, `beat_idx` goes up by one modulo 4. The advance after beat 3 returns to beat 0 and to the starting low bits, with no carry out of the group.
- R6: At an edge with `clk_en_n` = 1, `low_addr` and `beat_idx` keep their values. This holds whatever `adv_ld` and `start_addr` are.
- R7: The block samples `order_sel` only while `rst` is high. A change on `order_sel` after reset has no effect on the order until the next reset.
- R8: A load in the middle of a burst restarts at beat 0 with the new start value, from any beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also latches the order strap |
| clk_en_n | input | 1 | Active-low clock enable; when high the edge is ignored |
| adv_ld | input | 1 | 1 = advance one beat, 0 = load a new start value |
| order_sel | input | 1 | Order strap: 0 = linear, 1 = interleaved |
| start_addr | input | 2 | Starting low address bits, taken on a load |
| low_addr | output | 2 | Low address bits for the current beat |
| beat_idx | output | 2 | Beat number inside the burst, 0 to 3 |

## Verification
The bench goes through every start value in both orders and keeps advancing past the fourth beat. A counter that carried into a fifth state, or one that did not return to the starting bits, would show a wrong value on that wrap. It holds the clock enable high while it toggles `adv_ld` and changes `start_addr`. A design that let a disabled edge load or step would move the outputs during that stall. It also changes the strap after reset and issues loads from the middle of a burst. Wrong sampling of the strap would switch the order at once, and wrong load priority would continue the old burst instead of restarting at beat 0.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

    typedef struct packed {
        beat_t base;
        beat_t beat;
    } burst_state_t;

    typedef enum logic [1:0] {
        CMD_HOLD    = 2'd0,
        CMD_LOAD    = 2'd1,
        CMD_ADVANCE = 2'd2
    } burst_cmd_e;

    function automatic burst_cmd_e decode_cmd(input logic en_n, input logic adv);
        if (en_n)
            return CMD_HOLD;
        else if (adv)
            return CMD_ADVANCE;
        else
            return CMD_LOAD;
    endfunction

    function automatic beat_t linear_addr(input beat_t base, input beat_t beat);
        return beat_t'(base + beat);
    endfunction

    function automatic beat_t interleaved_addr(input beat_t base, input beat_t beat);
        return base ^ beat;
    endfunction

endpackage

// File: rtl/burst_mode_strap.sv
module burst_mode_strap
    import burst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strap_in,
    output order_e order_q
);

    always_ff @(posedge clk) begin
        if (rst)
            order_q <= order_e'(strap_in);
    end

    // R7: strap latched only in reset
    assert_strap_held_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(order_q));

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en_n,
    input  logic         adv,
    input  beat_t        start_in,
    output burst_state_t state_q
);

    burst_cmd_e   cmd;
    burst_state_t state_d;

    always_comb begin
        cmd     = decode_cmd(en_n, adv);
        state_d = state_q;
        unique case (cmd)
            CMD_LOAD: begin
                state_d.base = start_in;
                state_d.beat = '0;
            end
            CMD_ADVANCE: begin
                state_d.beat = beat_t'(state_q.beat + 1'b1);
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '{base: '0, beat: '0};
        else
            state_q <= state_d;
    end

    assert_stall_holds_R6: assert property (@(posedge clk) disable iff (rst)
        en_n |=> $stable(state_q));

    assert_load_restarts_R2: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !adv) |=> (state_q.beat == '0) && (state_q.base == $past(start_in)));

    assert_step_wraps_R5: assert property (@(posedge clk) disable iff (rst)
        (!en_n && adv) |=> (state_q.beat == beat_t'($past(state_q.beat) + 1'b1))
                           && $stable(state_q.base));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  order_e       order,
    input  burst_state_t state,
    output beat_t        addr_out
);

    beat_t lin_addr;
    beat_t ilv_addr;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_order
            if (g == 0) begin : g_lin
                assign lin_addr = linear_addr(state.base, state.beat);
            end else begin : g_ilv
                assign ilv_addr = interleaved_addr(state.base, state.beat);
            end
        end
    endgenerate

    assign addr_out = (order == ORDER_INTERLEAVED) ? ilv_addr : lin_addr;

    assert_linear_order_R3: assert property (@(posedge clk) disable iff (rst)
        (order == ORDER_LINEAR) |-> (beat_t'(addr_out - state.base) == state.beat));

    assert_interleaved_order_R4: assert property (@(posedge clk) disable iff (rst)
        (order == ORDER_INTERLEAVED) |-> ((addr_out ^ state.base) == state.beat));

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              adv_ld,
    input  logic              order_sel,
    input  logic [BEAT_W-1:0] start_addr,
    output logic [BEAT_W-1:0] low_addr,
    output logic [BEAT_W-1:0] beat_idx
);

    order_e       order_q;
    burst_state_t state_q;
    beat_t        mapped;

    burst_mode_strap u_strap (
        .clk      (clk),
        .rst      (rst),
        .strap_in (order_sel),
        .order_q  (order_q)
    );

    burst_beat_counter u_count (
        .clk      (clk),
        .rst      (rst),
        .en_n     (clk_en_n),
        .adv      (adv_ld),
        .start_in (start_addr),
        .state_q  (state_q)
    );

    burst_order_map u_map (
        .clk      (clk),
        .rst      (rst),
        .order    (order_q),
        .state    (state_q),
        .addr_out (mapped)
    );

    assign low_addr = mapped;
    assign beat_idx = state_q.beat;

    // R8: a load mid-burst restarts from beat 0 and shows the new start
    assert_midburst_load_R8: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !adv_ld && (beat_idx != '0)) |=>
            (beat_idx == '0) && (low_addr == $past(start_addr)));

endmodule

// File: tb/sim_burst_seq_top.sv
module sim_burst_seq_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       clk_en_n;
    logic       adv_ld;
    logic       order_sel;
    logic [1:0] start_addr;
    logic [1:0] low_addr;
    logic [1:0] beat_idx;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int m_base = 0;
    int m_beat = 0;
    int m_mode = 0;

    always #4 clk = ~clk;

    burst_seq_top u0 (
        .clk        (clk),
        .rst        (rst),
        .clk_en_n   (clk_en_n),
        .adv_ld     (adv_ld),
        .order_sel  (order_sel),
        .start_addr (start_addr),
        .low_addr   (low_addr),
        .beat_idx   (beat_idx)
    );

    function automatic int exp_addr();
        if (m_mode != 0)
            return m_base ^ m_beat;
        else
            return (m_base + m_beat) % 4;
    endfunction

    task automatic cycle(input logic r, input logic en_n, input logic adv,
                         input logic mode, input int start, input string req);
        @(negedge clk);
        rst        = r;
        clk_en_n   = en_n;
        adv_ld     = adv;
        order_sel  = mode;
        start_addr = start[1:0];
        @(posedge clk);
        if (r) begin
            m_base = 0;
            m_beat = 0;
            m_mode = mode ? 1 : 0;
        end else if (!en_n) begin
            if (!adv) begin
                m_base = start % 4;
                m_beat = 0;
            end else begin
                m_beat = (m_beat + 1) % 4;
            end
        end
        #1;
        checks++;
        if (int'(low_addr) != exp_addr() || int'(beat_idx) != m_beat) begin
            errors++;
            $display("FAIL %s: low_addr=%0d beat_idx=%0d expected low_addr=%0d beat_idx=%0d",
                     req, low_addr, beat_idx, exp_addr(), m_beat);
        end
    endtask

    task automatic run_order(input logic mode, input string req);
        cycle(1'b1, 1'b0, 1'b1, mode, 2, "R1");
        cycle(1'b1, 1'b1, 1'b0, mode, 3, "R1");
        for (int s = 0; s < 4; s++) begin
            cycle(1'b0, 1'b0, 1'b0, mode, s, "R2");
            for (int b = 0; b < 5; b++)
                cycle(1'b0, 1'b0, 1'b1, mode, (s + 1) % 4, req);
            cycle(1'b0, 1'b0, 1'b1, mode, s, "R5");
        end
        // stall mid-burst: load and advance attempts with enable inactive
        cycle(1'b0, 1'b0, 1'b0, mode, 1, "R2");
        cycle(1'b0, 1'b0, 1'b1, mode, 0, req);
        cycle(1'b0, 1'b1, 1'b0, mode, 3, "R6");
        cycle(1'b0, 1'b1, 1'b1, mode, 2, "R6");
        cycle(1'b0, 1'b1, 1'b0, mode, 0, "R6");
        cycle(1'b0, 1'b0, 1'b1, mode, 0, req);
        // strap changed after reset: order must not follow it
        cycle(1'b0, 1'b0, 1'b1, ~mode, 0, "R7");
        cycle(1'b0, 1'b0, 1'b1, ~mode, 0, "R7");
        cycle(1'b0, 1'b0, 1'b0, ~mode, 2, "R7");
        cycle(1'b0, 1'b0, 1'b1, ~mode, 0, "R7");
        cycle(1'b0, 1'b0, 1'b1, ~mode, 0, "R7");
        // loads from every beat position
        for (int p = 1; p < 4; p++) begin
            cycle(1'b0, 1'b0, 1'b1, mode, 0, req);
            cycle(1'b0, 1'b0, 1'b0, mode, p, "R8");
            for (int k = 0; k < p; k++)
                cycle(1'b0, 1'b0, 1'b1, mode, 3, "R8");
        end
    endtask

    initial begin
        rst        = 1'b1;
        clk_en_n   = 1'b1;
        adv_ld     = 1'b0;
        order_sel  = 1'b0;
        start_addr = 2'd0;
        run_order(1'b0, "R3");
        run_order(1'b1, "R4");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule